// File: doc/BRIEF.md
# Per-Core Cache Way Partition Registers

This block keeps, for every processor core and for one shared I/O agent, an 8-bit mask of cache ways that the agent may not allocate into. A set bit blocks the matching way. Software reaches the masks through a small register port that addresses them by core index, or by a flag that selects the I/O agent. Each write is reduced to the ways that actually exist. A write that would block every existing way is refused. A write or read for a core index the block was not built for is also refused.

The masks are packed four to a 64-bit word. Core index bits [1:0] times 8 give the byte offset of a field, and index bits [3:2] pick the word. The I/O agent mask takes the low byte of a fifth word. A write changes only its own byte. The allocation query port is combinational. A requester presents its identity and a vector of candidate ways. The block returns the candidates its mask leaves open, the lowest-numbered of them as the victim, and a flag when none is left.

Top module: `way_partition_regs`

## Requirements
- R1: After reset every mask is zero. Reads return 0, and every candidate way is permitted for every requester.
- R2: A write to core c stores into byte c[1:0] of word c[3:2]. The other three fields of that word keep their values.
- R3: Write data is ANDed with (1 << NUM_WAYS) - 1 before it is stored, so a read returns zero above bit NUM_WAYS-1.
- R4: A write whose reduced value equals (1 << NUM_WAYS) - 1 is refused with cfg_err = 1, and the stored mask does not change.
- R5: A request with cfg_hw = 0 and cfg_core >= NUM_CORES is refused with cfg_err = 1 and read data 0. An allocation query from such a core sees an all-zero mask.
- R6: With cfg_hw = 1 the access goes to the I/O agent mask and ignores cfg_core. The same reduction and full-block refusal rules apply, and the core masks are untouched.
- R7: alloc_allow equals alloc_cand AND NOT the requester's mask, in the same cycle as the query.
- R8: alloc_victim is the index of the lowest set bit of alloc_allow. When alloc_allow is zero, alloc_none = 1 and alloc_victim = 0.
- R9: A request accepted on a clock edge gives cfg_ack = 1 for exactly one cycle after that edge, together with cfg_err and cfg_rdata. Writes and refused requests return cfg_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Register request valid |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_hw | input | 1 | Select the I/O agent mask instead of a core mask |
| cfg_core | input | 4 | Core index |
| cfg_wdata | input | 8 | Write mask |
| cfg_ack | output | 1 | Response valid, one cycle after the request |
| cfg_err | output | 1 | Request refused |
| cfg_rdata | output | 8 | Read mask, zero-extended |
| alloc_hw | input | 1 | Requester is the I/O agent |
| alloc_core | input | 4 | Requesting core index |
| alloc_cand | input | NUM_WAYS | Candidate ways |
| alloc_allow | output | NUM_WAYS | Candidate ways the mask leaves open |
| alloc_victim | output | WIW | Lowest permitted way |
| alloc_none | output | 1 | No permitted way remains |

## Verification
The bench first writes the four cores that share one word with different byte values, then reads each back. A packing or offset slip shows up as a swapped or cleared neighbour. Write values with bits above the way count, values that block every way, out-of-range core indices and I/O agent accesses each tell apart the reduction, refusal and routing rules. Allocation queries use masks that leave the lowest, a middle and no way open, plus an out-of-range requester. This separates the masking from the victim priority.

// File: rtl/way_partition_regs.sv
module way_partition_regs #(
  parameter int NUM_CORES = 12,
  parameter int NUM_WAYS  = 6,
  localparam int WIW      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic                cfg_wr,
  input  logic                cfg_hw,
  input  logic [3:0]          cfg_core,
  input  logic [7:0]          cfg_wdata,
  output logic                cfg_ack,
  output logic                cfg_err,
  output logic [7:0]          cfg_rdata,
  input  logic                alloc_hw,
  input  logic [3:0]          alloc_core,
  input  logic [NUM_WAYS-1:0] alloc_cand,
  output logic [NUM_WAYS-1:0] alloc_allow,
  output logic [WIW-1:0]      alloc_victim,
  output logic                alloc_none
);

  localparam logic [7:0] VALID8 = 8'((1 << NUM_WAYS) - 1);
  localparam int NWORDS = 5;

  logic [63:0] bank [0:NWORDS-1];

  logic [2:0] cw;
  logic [1:0] co;
  logic [7:0] cfield, masked;
  logic       bad_idx, full, refuse;

  assign cw      = cfg_hw ? 3'd4 : {1'b0, cfg_core[3:2]};
  assign co      = cfg_hw ? 2'd0 : cfg_core[1:0];
  assign cfield  = bank[cw][{co, 3'b000} +: 8];
  assign masked  = cfg_wdata & VALID8;
  assign bad_idx = !cfg_hw && ({1'b0, cfg_core} >= 5'(NUM_CORES));
  assign full    = cfg_wr && (masked == VALID8);
  assign refuse  = bad_idx || full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) bank[i] <= '0;
    end else if (cfg_en && cfg_wr && !refuse) begin
      bank[cw][{co, 3'b000} +: 8] <= masked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ack   <= 1'b0;
      cfg_err   <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      cfg_ack   <= cfg_en;
      cfg_err   <= cfg_en && refuse;
      cfg_rdata <= (cfg_en && !cfg_wr && !refuse) ? cfield : 8'h00;
    end
  end

  logic [2:0] aw;
  logic [1:0] ao;
  logic [7:0] afield;

  assign aw          = alloc_hw ? 3'd4 : {1'b0, alloc_core[3:2]};
  assign ao          = alloc_hw ? 2'd0 : alloc_core[1:0];
  assign afield      = bank[aw][{ao, 3'b000} +: 8];
  assign alloc_allow = alloc_cand & ~afield[NUM_WAYS-1:0];
  assign alloc_none  = (alloc_allow == '0);

  always_comb begin
    alloc_victim = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--)
      if (alloc_allow[i]) alloc_victim = WIW'(i);
  end

endmodule

// File: rtl/way_partition_regs_chk.sv
module way_partition_regs_chk #(
  parameter int NUM_CORES = 12,
  parameter int NUM_WAYS  = 6,
  localparam int WIW      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_en,
  input logic                cfg_wr,
  input logic                cfg_hw,
  input logic [3:0]          cfg_core,
  input logic [7:0]          cfg_wdata,
  input logic                cfg_ack,
  input logic                cfg_err,
  input logic [7:0]          cfg_rdata,
  input logic                alloc_hw,
  input logic [3:0]          alloc_core,
  input logic [NUM_WAYS-1:0] alloc_cand,
  input logic [NUM_WAYS-1:0] alloc_allow,
  input logic [WIW-1:0]      alloc_victim,
  input logic                alloc_none
);

  localparam logic [7:0] VALID8 = 8'((1 << NUM_WAYS) - 1);

  p_ack_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_ack);
  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !cfg_ack);
  p_err_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> cfg_rdata == 8'h00);
  p_rdata_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~VALID8) == 8'h00);
  p_full_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_wr && ((cfg_wdata & VALID8) == VALID8)) |=> cfg_err);
  p_bad_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_hw && ({1'b0, cfg_core} >= 5'(NUM_CORES))) |=> cfg_err);
  p_oob_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_hw && ({1'b0, alloc_core} >= 5'(NUM_CORES))) |-> alloc_allow == alloc_cand);
  p_allow_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_allow & ~alloc_cand) == '0);
  p_victim_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_none |-> alloc_allow[alloc_victim]);
  p_victim_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_none |-> ((alloc_allow & ((1 << alloc_victim) - 1)) == '0));
  p_none_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_none |-> (alloc_victim == '0 && alloc_allow == '0));

endmodule

bind way_partition_regs way_partition_regs_chk #(
  .NUM_CORES(NUM_CORES), .NUM_WAYS(NUM_WAYS)
) u_chk (.*);

// File: tb/test_way_partition_regs.sv
module test_way_partition_regs;
  localparam int NC = 12;
  localparam int NW = 6;
  localparam int WIW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_wr = 0, cfg_hw = 0;
  logic [3:0] cfg_core = 0;
  logic [7:0] cfg_wdata = 0;
  logic cfg_ack, cfg_err;
  logic [7:0] cfg_rdata;
  logic alloc_hw = 0;
  logic [3:0] alloc_core = 0;
  logic [NW-1:0] alloc_cand = 0;
  logic [NW-1:0] alloc_allow;
  logic [WIW-1:0] alloc_victim;
  logic alloc_none;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  way_partition_regs #(.NUM_CORES(NC), .NUM_WAYS(NW)) i_way_partition_regs (.*);

  // {req[3:0], wr, hw, core[3:0], wdata[7:0], exp_err, exp_rdata[7:0]}
  localparam int NV = 28;
  localparam logic [26:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b0, 4'd0,  8'h00, 1'b0, 8'h00}, // R1 reset read
    {4'd2, 1'b1, 1'b0, 4'd0,  8'h05, 1'b0, 8'h00}, // R2
    {4'd2, 1'b1, 1'b0, 4'd1,  8'h0A, 1'b0, 8'h00},
    {4'd2, 1'b1, 1'b0, 4'd2,  8'h30, 1'b0, 8'h00},
    {4'd2, 1'b1, 1'b0, 4'd3,  8'h11, 1'b0, 8'h00},
    {4'd2, 1'b0, 1'b0, 4'd0,  8'h00, 1'b0, 8'h05},
    {4'd2, 1'b0, 1'b0, 4'd1,  8'h00, 1'b0, 8'h0A},
    {4'd2, 1'b0, 1'b0, 4'd2,  8'h00, 1'b0, 8'h30},
    {4'd2, 1'b0, 1'b0, 4'd3,  8'h00, 1'b0, 8'h11},
    {4'd3, 1'b1, 1'b0, 4'd5,  8'hC3, 1'b0, 8'h00}, // R3
    {4'd3, 1'b0, 1'b0, 4'd5,  8'h00, 1'b0, 8'h03},
    {4'd4, 1'b1, 1'b0, 4'd5,  8'hFF, 1'b1, 8'h00}, // R4
    {4'd4, 1'b0, 1'b0, 4'd5,  8'h00, 1'b0, 8'h03},
    {4'd4, 1'b1, 1'b0, 4'd6,  8'h3F, 1'b1, 8'h00},
    {4'd4, 1'b0, 1'b0, 4'd6,  8'h00, 1'b0, 8'h00},
    {4'd5, 1'b1, 1'b0, 4'd12, 8'h01, 1'b1, 8'h00}, // R5
    {4'd5, 1'b0, 1'b0, 4'd12, 8'h00, 1'b1, 8'h00},
    {4'd5, 1'b0, 1'b0, 4'd15, 8'h00, 1'b1, 8'h00},
    {4'd5, 1'b1, 1'b0, 4'd11, 8'h20, 1'b0, 8'h00},
    {4'd5, 1'b0, 1'b0, 4'd11, 8'h00, 1'b0, 8'h20},
    {4'd6, 1'b1, 1'b1, 4'd15, 8'h07, 1'b0, 8'h00}, // R6
    {4'd6, 1'b0, 1'b1, 4'd2,  8'h00, 1'b0, 8'h07},
    {4'd6, 1'b1, 1'b1, 4'd0,  8'h3F, 1'b1, 8'h00},
    {4'd6, 1'b0, 1'b1, 4'd0,  8'h00, 1'b0, 8'h07},
    {4'd6, 1'b0, 1'b0, 4'd3,  8'h00, 1'b0, 8'h11},
    {4'd6, 1'b0, 1'b0, 4'd0,  8'h00, 1'b0, 8'h05},
    {4'd3, 1'b1, 1'b0, 4'd0,  8'h40, 1'b0, 8'h00},
    {4'd3, 1'b0, 1'b0, 4'd0,  8'h00, 1'b0, 8'h00}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input int req, input logic wr, input logic hw, input logic [3:0] core,
                    input logic [7:0] wd, input logic eerr, input logic [7:0] erd);
    cfg_en = 1; cfg_wr = wr; cfg_hw = hw; cfg_core = core; cfg_wdata = wd;
    @(posedge clk); @(negedge clk);
    cfg_en = 0;
    check($sformatf("R%0d ack core %0d", req, core), 16'(cfg_ack), 16'd1);
    check($sformatf("R%0d err core %0d", req, core), 16'(cfg_err), 16'(eerr));
    check($sformatf("R%0d rdata core %0d", req, core), 16'(cfg_rdata), 16'(erd));
  endtask

  task automatic query(input string tag, input logic hw, input logic [3:0] core,
                       input logic [NW-1:0] cand, input logic [NW-1:0] eallow,
                       input logic [WIW-1:0] evic, input logic enone);
    alloc_hw = hw; alloc_core = core; alloc_cand = cand;
    #1;
    check({tag, " allow"}, 16'(alloc_allow), 16'(eallow));
    check({tag, " victim"}, 16'(alloc_victim), 16'(evic));
    check({tag, " none"}, 16'(alloc_none), 16'(enone));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ack idle", 16'(cfg_ack), 16'd0);
    query("R1 reset c0", 1'b0, 4'd0, 6'h3F, 6'h3F, 3'd0, 1'b0);
    query("R1 reset hw", 1'b1, 4'd0, 6'h15, 6'h15, 3'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      op(int'(v[26:23]), v[22], v[21], v[20:17], v[16:9], v[8], v[7:0]);
    end
    @(negedge clk);
    check("R9 ack one cycle", 16'(cfg_ack), 16'd0);

    query("R7 c1", 1'b0, 4'd1, 6'h3F, 6'h35, 3'd0, 1'b0);
    query("R7 c2", 1'b0, 4'd2, 6'h3F, 6'h0F, 3'd0, 1'b0);
    query("R8 c5", 1'b0, 4'd5, 6'h3F, 6'h3C, 3'd2, 1'b0);
    query("R6 hw", 1'b1, 4'd1, 6'h0F, 6'h08, 3'd3, 1'b0);
    query("R8 c11 none", 1'b0, 4'd11, 6'h20, 6'h00, 3'd0, 1'b1);
    query("R7 c3", 1'b0, 4'd3, 6'h22, 6'h22, 3'd1, 1'b0);
    query("R5 c13 free", 1'b0, 4'd13, 6'h3F, 6'h3F, 3'd0, 1'b0);

    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    query("R1 after reset c1", 1'b0, 4'd1, 6'h3F, 6'h3F, 3'd0, 1'b0);
    op(1, 1'b0, 1'b0, 4'd3, 8'h00, 1'b0, 8'h00);
    op(1, 1'b0, 1'b1, 4'd0, 8'h00, 1'b0, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule